// File: doc/BRIEF.md
# Clock-Stop SPI Master

This block is a serial-port master that moves one word at a time over a four-wire synchronous serial link. The serial clock runs only while a word is on the wire. The parallel side offers one word through a valid/ready pair. The block then pulls its active-low select line low and drives the word most significant bit first on its data output. It samples the returning data input and hands the received word back with a one-cycle valid pulse.

The serial clock comes from a divider. Its input is a base tick S, which is either one pulse every two system clocks or an external enable pulse. A divide value D sets the serial period to D+1 ticks. The high and low phase widths follow the parity of D. A polarity input picks the rest level of the clock and so decides which edge samples and which edge shifts. All logic runs on the system clock, and the serial clock is a registered level that changes only on qualified ticks.

Top module: `spi_cs_master`

## Requirements
- R1: When select falls, the serial clock is at its rest level. The first clock edge comes one full serial period (D+1 ticks) after select falls.
- R2: With the effective divide value d, the phase after each sampling edge lasts A = floor((d+2)/2) ticks and the phase after each shifting edge lasts d+1-A ticks. This gives high/low widths of d/2+1 and d/2 for even d, and (d+1)/2 each for odd d.
- R3: A divide value of 0 behaves exactly as a divide value of 1.
- R4: Transmit data leaves MSB first. The first bit is on `dx_o` from the cycle in which select falls, and each later bit changes only on the edge that returns the clock to rest.
- R5: `dr` is sampled on each edge that leaves the rest level. After the last sample, `rx_valid` is high for exactly one cycle. `rx_data` then holds the word right-aligned, first-received bit most significant, with all bits above the word length zero.
- R6: The rest level equals `cpol` (0: low, so rising edges sample; 1: high, so falling edges sample). The clock sits at rest between transfers.
- R7: Select rises d+1-A ticks after the final return-to-rest edge. `dx_oe` is high exactly while select is low.
- R8: `tx_ready` is high only when idle. `busy` is high from select fall to select rise. A `tx_valid` during a transfer is ignored and starts no further transfer.
- R9: While `rst_n` is low at a clock edge, the block goes idle: select high, `dx_oe` low, clock at rest, `rx_valid` low. This applies in the middle of a transfer as well.
- R10: `word_len` values below 8 act as 8 and values above 32 act as 32. The transfer carries exactly that many bits, which means twice that many clock edges.
- R11: With `src_int`=1, one tick is two system clocks, and the tick phase restarts when a word is accepted, so the timings in R1, R2 and R7 are exact in system clocks. With `src_int`=0, each high cycle of `ext_en` is one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_int | input | 1 | 1: tick every two system clocks; 0: tick on `ext_en` |
| ext_en | input | 1 | External tick enable pulse |
| div_val | input | DIV_W | Divide value D |
| cpol | input | 1 | Clock rest level / edge selection |
| word_len | input | LEN_W | Bits per word (clamped to 8..MAX_LEN) |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | MAX_LEN | Transmit word, right-aligned |
| tx_ready | output | 1 | Idle, word can be accepted |
| rx_valid | output | 1 | One-cycle received-word strobe |
| rx_data | output | MAX_LEN | Received word, right-aligned |
| busy | output | 1 | Select is asserted |
| sclk | output | 1 | Serial clock |
| sel_n | output | 1 | Active-low slave select |
| dx_o | output | 1 | Serial data out |
| dx_oe | output | 1 | Output enable for `dx_o` |
| dr | input | 1 | Serial data in |

## Verification
The assertions assume that `cpol`, `div_val` and `word_len` change only while the block is idle. They also assume that the tick source does not switch during a transfer. The stimulus changes configuration only between words, and it waits one extra cycle after a polarity change before offering the next word. The bench changes `dr` only just after a sampling edge, so the sampled value is always settled. Divide values 0 to 5, both polarities and three word lengths are swept with internal ticks, which keeps the cycle counts exact.

// File: rtl/spi_cs_pkg.sv
// Shared types for the clock-stop serial master.
// Assumes nothing beyond IEEE 1800-2017.
package spi_cs_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_LEAD = 2'd1,
        SQ_ACT  = 2'd2,
        SQ_REST = 2'd3
    } seq_st_t;
endpackage

// File: rtl/spi_cs_tick.sv
// Base tick source S: either a toggle giving one tick every two system
// clocks (phase restarted on word accept) or an external enable pulse.
// Assumes src_int is held steady during a transfer.
module spi_cs_tick (
    input  logic clk,
    input  logic rst_n,
    input  logic src_int,
    input  logic ext_en,
    input  logic restart,
    output logic tick
);
    logic half;

    // Half-rate toggle, realigned when a word is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)       half <= 1'b0;
        else if (restart) half <= 1'b0;
        else              half <= ~half;
    end

    assign tick = src_int ? half : ext_en;
endmodule

// File: rtl/spi_cs_seq.sv
// Transfer sequencer: owns select, serial clock level and phase timing.
// Counts S ticks for the lead period, the phase after each sampling edge
// (A ticks) and the phase after each shifting edge (B ticks).
// Assumes cpol/div_val/word_len are only changed while idle.
module spi_cs_seq
    import spi_cs_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cpol,
    input  logic [DIV_W-1:0] div_val,
    input  logic [LEN_W-1:0] len_c,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic             accept,
    output logic             smp,
    output logic             last_smp,
    output logic             shf,
    output logic             rel,
    output logic             sclk,
    output logic             sel_n
);
    localparam int CW = DIV_W + 1;

    seq_st_t          st;
    logic [CW-1:0]    cnt;
    logic [CW-1:0]    act_q;
    logic [CW-1:0]    rst_q;
    logic [LEN_W-1:0] bits;
    logic             pol_q;
    logic             done;
    logic [DIV_W-1:0] div_eff;
    logic [CW-1:0]    per_w;
    logic [CW-1:0]    act_w;

    // Phase widths from the effective divide value (0 acts as 1).
    always_comb begin
        div_eff = (div_val == '0) ? DIV_W'(1) : div_val;
        per_w   = CW'(div_eff) + CW'(1);
        act_w   = (CW'(div_eff) + CW'(2)) >> 1;
    end

    // Strobes for the shifter, decoded from state and tick.
    always_comb begin
        done     = tick && (cnt == CW'(1));
        tx_ready = (st == SQ_IDLE);
        accept   = tx_ready && tx_valid;
        smp      = done && ((st == SQ_LEAD) || (st == SQ_REST && bits != '0));
        last_smp = smp && (bits == LEN_W'(1));
        shf      = done && (st == SQ_ACT) && (bits != '0);
        rel      = done && (st == SQ_REST) && (bits == '0);
    end

    // Main sequencing of select, clock level and tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= SQ_IDLE;
            sel_n <= 1'b1;
            sclk  <= cpol;
            pol_q <= cpol;
            cnt   <= '0;
            bits  <= '0;
            act_q <= '0;
            rst_q <= '0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    sclk <= cpol;
                    if (accept) begin
                        sel_n <= 1'b0;
                        pol_q <= cpol;
                        cnt   <= per_w;
                        act_q <= act_w;
                        rst_q <= per_w - act_w;
                        bits  <= len_c;
                        st    <= SQ_LEAD;
                    end
                end
                SQ_LEAD: begin
                    if (done) begin
                        sclk <= ~pol_q;
                        cnt  <= act_q;
                        bits <= bits - LEN_W'(1);
                        st   <= SQ_ACT;
                    end else if (tick) begin
                        cnt <= cnt - CW'(1);
                    end
                end
                SQ_ACT: begin
                    if (done) begin
                        sclk <= pol_q;
                        cnt  <= rst_q;
                        st   <= SQ_REST;
                    end else if (tick) begin
                        cnt <= cnt - CW'(1);
                    end
                end
                default: begin
                    if (done) begin
                        if (bits == '0) begin
                            sel_n <= 1'b1;
                            st    <= SQ_IDLE;
                        end else begin
                            sclk <= ~pol_q;
                            cnt  <= act_q;
                            bits <= bits - LEN_W'(1);
                            st   <= SQ_ACT;
                        end
                    end else if (tick) begin
                        cnt <= cnt - CW'(1);
                    end
                end
            endcase
        end
    end

    AST_SCLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st != SQ_IDLE && !tick) |=> $stable(sclk)); // R2
    AST_SEL_FALL_REST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_n) |-> (sclk == pol_q)); // R1
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_n |-> !tx_ready); // R8
endmodule

// File: rtl/spi_cs_shift.sv
// Data path: transmit shifter (MSB out first), receive shifter and
// output-enable for the data line. Driven by sequencer strobes.
// Assumes len is already clamped to MIN..MAX_LEN.
module spi_cs_shift #(
    parameter int MAX_LEN = 32,
    parameter int LEN_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [MAX_LEN-1:0] tx_data,
    input  logic [LEN_W-1:0]   len,
    input  logic               shift,
    input  logic               sample,
    input  logic               last,
    input  logic               release_i,
    input  logic               dr,
    output logic               dx_o,
    output logic               dx_oe,
    output logic [MAX_LEN-1:0] rx_data,
    output logic               rx_valid
);
    logic [MAX_LEN-1:0] txs;
    logic [MAX_LEN-1:0] rxs;
    logic [LEN_W-1:0]   sh;

    // Left-align the word so its MSB sits at the top of the shifter.
    assign sh = LEN_W'(MAX_LEN) - len;

    // Transmit shifter and line enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txs   <= '0;
            dx_oe <= 1'b0;
        end else if (load) begin
            txs   <= tx_data << sh;
            dx_oe <= 1'b1;
        end else begin
            if (shift)     txs   <= txs << 1;
            if (release_i) dx_oe <= 1'b0;
        end
    end

    // Receive shifter with one-cycle completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxs      <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (load) begin
                rxs <= '0;
            end else if (sample) begin
                rxs <= {rxs[MAX_LEN-2:0], dr};
                if (last) begin
                    rx_data  <= {rxs[MAX_LEN-2:0], dr};
                    rx_valid <= 1'b1;
                end
            end
        end
    end

    assign dx_o = txs[MAX_LEN-1];

    AST_RXV_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R5
endmodule

// File: rtl/spi_cs_master.sv
// Clock-stop serial master top: clamps word length, wires tick source,
// sequencer and shifter. Assumes configuration is static while busy.
module spi_cs_master #(
    parameter int MAX_LEN = 32,
    parameter int MIN_LEN = 8,
    parameter int DIV_W   = 8,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               src_int,
    input  logic               ext_en,
    input  logic [DIV_W-1:0]   div_val,
    input  logic               cpol,
    input  logic [LEN_W-1:0]   word_len,
    input  logic               tx_valid,
    input  logic [MAX_LEN-1:0] tx_data,
    output logic               tx_ready,
    output logic               rx_valid,
    output logic [MAX_LEN-1:0] rx_data,
    output logic               busy,
    output logic               sclk,
    output logic               sel_n,
    output logic               dx_o,
    output logic               dx_oe,
    input  logic               dr
);
    logic             tick;
    logic             accept;
    logic             smp;
    logic             last_smp;
    logic             shf;
    logic             rel;
    logic [LEN_W-1:0] len_c;

    // Clamp the requested word length into the supported range.
    always_comb begin
        if (word_len < LEN_W'(MIN_LEN))      len_c = LEN_W'(MIN_LEN);
        else if (word_len > LEN_W'(MAX_LEN)) len_c = LEN_W'(MAX_LEN);
        else                                 len_c = word_len;
    end

    spi_cs_tick u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_int (src_int),
        .ext_en  (ext_en),
        .restart (accept),
        .tick    (tick)
    );

    spi_cs_seq #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cpol     (cpol),
        .div_val  (div_val),
        .len_c    (len_c),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .accept   (accept),
        .smp      (smp),
        .last_smp (last_smp),
        .shf      (shf),
        .rel      (rel),
        .sclk     (sclk),
        .sel_n    (sel_n)
    );

    spi_cs_shift #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .tx_data   (tx_data),
        .len       (len_c),
        .shift     (shf),
        .sample    (smp),
        .last      (last_smp),
        .release_i (rel),
        .dr        (dr),
        .dx_o      (dx_o),
        .dx_oe     (dx_oe),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid)
    );

    assign busy = ~sel_n;

    AST_OE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        dx_oe == !sel_n); // R7
endmodule

// File: tb/tb_spi_cs_master.sv
module tb_spi_cs_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_int = 1'b1;
    logic        ext_en = 1'b0;
    logic [7:0]  div_val = 8'd1;
    logic        cpol = 1'b0;
    logic [5:0]  word_len = 6'd8;
    logic        tx_valid = 1'b0;
    logic [31:0] tx_data = '0;
    logic        tx_ready, rx_valid, busy, sclk, sel_n, dx_o, dx_oe;
    logic [31:0] rx_data;
    logic        dr = 1'b0;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    spi_cs_master dut (
        .clk(clk), .rst_n(rst_n), .src_int(src_int), .ext_en(ext_en),
        .div_val(div_val), .cpol(cpol), .word_len(word_len),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .busy(busy), .sclk(sclk),
        .sel_n(sel_n), .dx_o(dx_o), .dx_oe(dx_oe), .dr(dr)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // External tick: one high cycle in every three.
    initial begin
        forever begin
            @(negedge clk); ext_en = 1'b0;
            @(negedge clk); ext_en = 1'b0;
            @(negedge clk); ext_en = 1'b1;
        end
    end

    task automatic run_xfer(input logic [31:0] txw, input logic [31:0] rxw,
                            input int lenin, input int divin, input logic pol,
                            input bit tmg, input bit poke);
        int len_e = (lenin < 8) ? 8 : ((lenin > 32) ? 32 : lenin);
        int d = (divin == 0) ? 1 : divin;
        int p = d + 1;
        int a = (d + 2) / 2;
        int b = p - a;
        logic [31:0] msk = (len_e == 32) ? 32'hFFFF_FFFF : ((32'd1 << len_e) - 1);
        logic [31:0] got_tx = '0;
        logic [31:0] got_rx = '0;
        int edges = 0, c = 0, last_t = 0, bitidx = 0, nrxv = 0, sel_rise = 0;
        int expd;
        bit done = 0;
        logic prev;
        @(negedge clk);
        cpol = pol; div_val = 8'(divin); word_len = 6'(lenin);
        dr = rxw[len_e-1];
        @(negedge clk);
        chk(sclk == pol && sel_n && tx_ready, "R6 rest level idle", sclk, pol);
        tx_valid = 1'b1; tx_data = txw;
        @(negedge clk);
        tx_valid = 1'b0;
        chk(!sel_n && busy && dx_oe, "R8 select/busy on accept", {sel_n, busy, dx_oe}, 3'b011);
        chk(dx_o == txw[len_e-1], "R4 first bit at select fall", dx_o, txw[len_e-1]);
        chk(sclk == pol, "R1 clock at rest when select falls", sclk, pol);
        prev = pol;
        while (!done && c < 20000) begin
            if (rx_valid) begin nrxv++; got_rx = rx_data; end
            if (sclk != prev) begin
                if (tmg) begin
                    expd = (edges == 0) ? 2 * p : ((edges % 2 == 1) ? 2 * a : 2 * b);
                    if (edges == 0) chk(c - last_t == expd, "R1 lead period", c - last_t, expd);
                    else chk(c - last_t == expd, "R2 phase width", c - last_t, expd);
                end
                if (edges % 2 == 0) begin
                    chk(sclk == ~pol, "R6 sampling edge leaves rest", sclk, ~pol);
                    got_tx = {got_tx[30:0], dx_o};
                    bitidx++;
                    if (bitidx < len_e) dr = rxw[len_e-1-bitidx];
                end
                last_t = c; edges++; prev = sclk;
            end
            if (sel_n) begin
                done = 1; sel_rise = c;
            end else if (tx_ready) begin
                chk(0, "R8 ready while busy", 1, 0);
            end
            if (poke && c == 3) begin tx_valid = 1'b1; tx_data = ~txw; end
            else tx_valid = 1'b0;
            if (!done) begin @(negedge clk); c++; end
        end
        tx_valid = 1'b0;
        if (rx_valid) begin nrxv++; got_rx = rx_data; end
        chk(edges == 2 * len_e, "R10 edge count", edges, 2 * len_e);
        chk((got_tx & msk) == (txw & msk), "R4 transmit bits", got_tx & msk, txw & msk);
        chk(got_rx == (rxw & msk), "R5 received word", got_rx, rxw & msk);
        chk(nrxv == 1, "R5 single valid pulse", nrxv, 1);
        if (tmg) chk(sel_rise - last_t == 2 * b, "R7 release delay", sel_rise - last_t, 2 * b);
        chk(!dx_oe && sclk == pol, "R7 line released at rest", {dx_oe, sclk}, {1'b0, pol});
        repeat (3) @(negedge clk);
        chk(sel_n && tx_ready && !rx_valid, "R8 no extra transfer", {sel_n, tx_ready}, 2'b11);
    endtask

    initial begin
        repeat (5000 * 30) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        cpol = 1'b1;
        repeat (3) @(negedge clk);
        chk(sel_n && !dx_oe && sclk == 1'b1 && !rx_valid && tx_ready, "R9 reset state",
            {sel_n, dx_oe, sclk, rx_valid}, 4'b1010);
        rst_n = 1'b1;
        // R2 R3 R6 sweep: polarity x divide 0..5 x length
        for (int pl = 0; pl < 2; pl++)
            for (int dv = 0; dv <= 5; dv++)
                for (int li = 0; li < 3; li++) begin
                    int ln = (li == 0) ? 8 : ((li == 1) ? 13 : 32);
                    logic [31:0] tw = 32'hA5C3_1E0F ^ (32'(dv * 7 + li + pl * 40) * 32'h9E37_79B9);
                    logic [31:0] rw = ~tw ^ 32'h0F0F_3355;
                    run_xfer(tw, rw, ln, dv, pl[0], 1'b1, 1'b0);
                end
        // R10 length clamp below and above
        run_xfer(32'h0000_00B6, 32'h0000_005D, 4, 2, 1'b0, 1'b1, 1'b0);
        run_xfer(32'hDEAD_BEEF, 32'h1234_5678, 40, 2, 1'b1, 1'b1, 1'b0);
        // R8 offer while busy is ignored
        run_xfer(32'h0000_C3A5, 32'h0000_5A3C, 16, 3, 1'b0, 1'b1, 1'b1);
        // R11 external tick source
        src_int = 1'b0;
        run_xfer(32'h0000_9E71, 32'h0000_2BD4, 16, 3, 1'b1, 1'b0, 1'b0);
        run_xfer(32'h0000_00E1, 32'h0000_0017, 8, 0, 1'b0, 1'b0, 1'b0);
        src_int = 1'b1;
        // R9 reset in the middle of a transfer
        @(negedge clk); cpol = 1'b0; div_val = 8'd4; word_len = 6'd16;
        @(negedge clk); tx_valid = 1'b1; tx_data = 32'h0000_FFFF;
        @(negedge clk); tx_valid = 1'b0;
        repeat (25) @(negedge clk);
        chk(!sel_n, "R9 transfer active before reset", sel_n, 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk(sel_n && !dx_oe && sclk == 1'b0 && !rx_valid, "R9 mid-transfer reset",
            {sel_n, dx_oe, sclk, rx_valid}, 4'b1000);
        rst_n = 1'b1;
        run_xfer(32'h0000_0081, 32'h0000_007E, 8, 1, 1'b0, 1'b1, 1'b0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule